// File: doc/BRIEF.md
# Divider and Waveform Clock Squasher

This block reduces the rate of one fast clock in three stages and reports the result as clock-enable pulses. No clock is gated. The first stage is an integer divider with a choice of four power-of-two ratios. The second stage is a squasher. It walks a 16-bit pattern once for each enable from the divider and drops every cycle that meets a zero bit. The third stage is a toggle flop that halves whatever the squasher lets through. The resulting rate is `f_in / divisor * (ones / 16) / 2`.

The divisor and the pattern change under different rules, because logic downstream consumes the pulses while the chain runs:

- **Divisor.** A new divisor takes effect only on a start-of-vblank strobe. The divider count then restarts from zero.
- **Pattern.** A new pattern is accepted at any time. It is parked and swapped in only when the pattern pointer wraps, so no mixed pattern is ever emitted.

Either of the first two stages can be bypassed, which makes its factor 1.

Top module: `clk_squash_chain`

## Requirements
- R1: After reset the toggle output `half_clk` is 0, the active divisor is 1, the pattern is all ones and the pointer is at bit 15. So `div_en` and `sq_en` are 1 and `half_en` is 0.
- R2: `div_sel` encodes the divisor as 00 = 1, 01 = 2, 10 = 4, 11 = 8. With the divider not bypassed, `div_en` pulses exactly once in every `divisor` cycles.
- R3: A change on `div_sel` has no effect until a cycle with `vblank_start` high. At that edge the new divisor is applied and the count restarts at zero, so the first `div_en` pulse appears `divisor-1` cycles after the strobe edge.
- R4: The squasher consumes the pattern starting at bit 15 and moving toward bit 0, one bit per `div_en` pulse, and wraps after bit 0. A 1 bit passes the pulse to `sq_en` and a 0 bit removes it.
- R5: Over a whole number of pattern periods, the number of `sq_en` pulses equals the number of `div_en` pulses times ones/16.
- R6: A pattern written with `wave_load` is used only from the next wrap of the pointer. Until then the current pattern keeps running unchanged.
- R7: A `wave_load` whose pattern is all zero is ignored, and the pattern in use is kept.
- R8: With `div_bypass` high, `div_en` is 1 on every cycle regardless of the active divisor.
- R9: With `sq_bypass` high, every `div_en` pulse appears on `sq_en` regardless of the pattern.
- R10: `half_clk` toggles on each `sq_en` pulse. `half_en` is high on the `sq_en` pulses that return `half_clk` from 1 to 0, which gives half the `sq_en` rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_sel | input | 2 | Requested divisor code |
| div_bypass | input | 1 | Forces the divider factor to 1 |
| vblank_start | input | 1 | Strobe that applies the requested divisor |
| wave_in | input | 16 | New squash pattern |
| wave_load | input | 1 | Request to park `wave_in` for the next wrap |
| sq_bypass | input | 1 | Forces the squasher factor to 1 |
| div_en | output | 1 | Enable after the divider |
| sq_en | output | 1 | Enable after the squasher |
| half_en | output | 1 | Enable after the divide-by-two |
| half_clk | output | 1 | Toggle output of the last stage |

## Verification
The bench loads a pattern right after reset and checks each output bit against the pattern from the wrap onward. A design that swapped the pattern in early, or read it from the wrong end, shows ones where zeros belong. It changes the divisor without a strobe and expects the old rate to remain. It then measures the delay from the strobe to the first pulse, which exposes a divider that applies the change at once or fails to restart its count. An all-zero load is sent while the chain runs, and the pulse count over whole periods must stay the same; a design that accepted it would fall silent.

// File: rtl/clksq_pkg.sv
package clksq_pkg;

    localparam int SEL_W  = 2;
    localparam int WAVE_W = 16;

    typedef enum logic [SEL_W-1:0] {
        DIV_BY1 = 2'b00,
        DIV_BY2 = 2'b01,
        DIV_BY4 = 2'b10,
        DIV_BY8 = 2'b11
    } div_code_e;

endpackage

// File: rtl/clksq_divider.sv
module clksq_divider #(
    parameter int SEL_W = clksq_pkg::SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel_req,
    input  logic             apply,
    input  logic             bypass,
    output logic             en_o
);
    localparam int MAX_SHIFT = (1 << SEL_W) - 1;
    localparam int CNT_W     = (MAX_SHIFT > 0) ? MAX_SHIFT : 1;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic [CNT_W-1:0] cnt;
    } div_st_t;

    div_st_t st_d, st_q;
    logic [CNT_W-1:0] lim;
    logic             at_lim;

    always_comb begin
        st_d   = st_q;
        lim    = {CNT_W{1'b1}} >> (MAX_SHIFT - int'(st_q.sel));
        at_lim = (st_q.cnt == lim);
        if (at_lim) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        if (apply) begin
            st_d.sel = sel_req;
            st_d.cnt = '0;
        end
        en_o = bypass | at_lim;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R3: the strobe restarts the count and loads the requested code
    assert_strobe_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        apply |=> (st_q.cnt == '0) && (st_q.sel == $past(sel_req)));

    // R3: without a strobe the active divisor holds
    assert_sel_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !apply |=> $stable(st_q.sel));

    // R2: the count never passes the limit of the active divisor
    assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= lim);

endmodule

// File: rtl/clksq_squasher.sv
module clksq_squasher #(
    parameter int WAVE_W = clksq_pkg::WAVE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_en,
    input  logic [WAVE_W-1:0] wave_in,
    input  logic              wave_load,
    input  logic              bypass,
    output logic              en_o
);
    localparam int PTR_W = (WAVE_W > 1) ? $clog2(WAVE_W) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(WAVE_W - 1);

    typedef struct packed {
        logic [WAVE_W-1:0] wave;
        logic [WAVE_W-1:0] pend;
        logic              pend_vld;
        logic [PTR_W-1:0]  ptr;
    } sq_st_t;

    sq_st_t st_d, st_q;
    logic [WAVE_W-1:0] wave_rev;
    logic              load_ok;
    logic              wrap;

    // Reverse the pattern so pointer 0 addresses the top bit
    for (genvar i = 0; i < WAVE_W; i++) begin : g_rev
        assign wave_rev[i] = st_q.wave[WAVE_W-1-i];
    end

    always_comb begin
        st_d    = st_q;
        load_ok = wave_load && (wave_in != '0);
        wrap    = in_en && (st_q.ptr == LAST);
        if (load_ok) begin
            st_d.pend     = wave_in;
            st_d.pend_vld = 1'b1;
        end
        if (in_en) begin
            st_d.ptr = st_q.ptr + 1'b1;
        end
        if (wrap && st_q.pend_vld) begin
            st_d.wave = st_q.pend;
            if (!load_ok) begin
                st_d.pend_vld = 1'b0;
            end
        end
        en_o = in_en && (bypass || wave_rev[st_q.ptr]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.wave     <= '1;
            st_q.pend     <= '1;
            st_q.pend_vld <= 1'b0;
            st_q.ptr      <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R6: the pattern in use changes only at a pointer wrap
    assert_swap_at_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_en && (st_q.ptr == LAST)) |=> $stable(st_q.wave));

    // R7: the pattern in use is never all zero
    assert_wave_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.wave != '0);

    // R4: the pointer steps only on an incoming enable
    assert_ptr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !in_en |=> $stable(st_q.ptr));

    // R9: no output pulse without an input pulse
    assert_no_spurious_R9: assert property (@(posedge clk) disable iff (!rst_n)
        en_o |-> in_en);

endmodule

// File: rtl/clksq_halver.sv
module clksq_halver (
    input  logic clk,
    input  logic rst_n,
    input  logic in_en,
    output logic en_o,
    output logic half_o
);
    logic tog_d, tog_q;

    always_comb begin
        tog_d  = tog_q ^ in_en;
        en_o   = in_en & tog_q;
        half_o = tog_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tog_q <= 1'b0;
        end else begin
            tog_q <= tog_d;
        end
    end

    // R10: every incoming pulse flips the toggle
    assert_toggle_flip_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_en |=> (tog_q != $past(tog_q)));

    // R10: idle cycles leave the toggle alone
    assert_toggle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_en |=> $stable(tog_q));

endmodule

// File: rtl/clk_squash_chain.sv
module clk_squash_chain #(
    parameter int SEL_W  = clksq_pkg::SEL_W,
    parameter int WAVE_W = clksq_pkg::WAVE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  div_sel,
    input  logic              div_bypass,
    input  logic              vblank_start,
    input  logic [WAVE_W-1:0] wave_in,
    input  logic              wave_load,
    input  logic              sq_bypass,
    output logic              div_en,
    output logic              sq_en,
    output logic              half_en,
    output logic              half_clk
);
    clksq_divider #(.SEL_W(SEL_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_req (div_sel),
        .apply   (vblank_start),
        .bypass  (div_bypass),
        .en_o    (div_en)
    );

    clksq_squasher #(.WAVE_W(WAVE_W)) u_sq (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_en     (div_en),
        .wave_in   (wave_in),
        .wave_load (wave_load),
        .bypass    (sq_bypass),
        .en_o      (sq_en)
    );

    clksq_halver u_half (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_en  (sq_en),
        .en_o   (half_en),
        .half_o (half_clk)
    );

    // R10: the final enable is a subset of the squasher enable
    assert_half_subset_R10: assert property (@(posedge clk) disable iff (!rst_n)
        half_en |-> sq_en);

endmodule

// File: tb/tb_clk_squash_chain.sv
module tb_clk_squash_chain;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  div_sel = 2'b00;
    logic        div_bypass = 1'b0;
    logic        vblank_start = 1'b0;
    logic [15:0] wave_in = 16'h0;
    logic        wave_load = 1'b0;
    logic        sq_bypass = 1'b0;
    logic        div_en, sq_en, half_en, half_clk;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    clk_squash_chain dut (
        .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .div_bypass(div_bypass),
        .vblank_start(vblank_start), .wave_in(wave_in), .wave_load(wave_load),
        .sq_bypass(sq_bypass), .div_en(div_en), .sq_en(sq_en),
        .half_en(half_en), .half_clk(half_clk)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // All inputs change at negedges; outputs are sampled at negedges
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; div_sel = 2'b00; div_bypass = 1'b0; vblank_start = 1'b0;
        wave_in = 16'h0; wave_load = 1'b0; sq_bypass = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic count_win(input int n, output int nd, output int ns, output int nh);
        nd = 0; ns = 0; nh = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            nd += int'(div_en); ns += int'(sq_en); nh += int'(half_en);
        end
    endtask

    task automatic strobe(input logic [1:0] code);
        div_sel = code;
        vblank_start = 1'b1;
        @(negedge clk);
        vblank_start = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        chk("R1 half_clk", int'(half_clk), 0);
        chk("R1 div_en", int'(div_en), 1);
        chk("R1 sq_en", int'(sq_en), 1);
        chk("R1 half_en", int'(half_en), 0);
    endtask

    task automatic t_div_ratios();
        int nd, ns, nh;
        do_reset();
        for (int c = 0; c < 4; c++) begin
            strobe(2'(c));
            count_win(64, nd, ns, nh);
            chk($sformatf("R2 div_en count code %0d", c), nd, 64 >> c);
            chk($sformatf("R10 half_en count code %0d", c), nh, 32 >> c);
        end
    endtask

    task automatic t_strobe_rule();
        int nd, ns, nh, first;
        do_reset();
        div_sel = 2'b11;
        count_win(32, nd, ns, nh);
        chk("R3 no change without strobe", nd, 32);
        strobe(2'b11);
        first = 0;
        for (int s = 1; s <= 12; s++) begin
            @(negedge clk);
            if (div_en && first == 0) first = s;
        end
        chk("R3 first pulse after strobe", first, 7);
    endtask

    task automatic t_pattern();
        int nd, ns, nh, bad_old, bad_new;
        logic [15:0] w;
        w = 16'hF0A1;
        do_reset();
        wave_in = w; wave_load = 1'b1;
        bad_old = 0; bad_new = 0;
        for (int s = 1; s <= 31; s++) begin
            @(negedge clk);
            if (s <= 15) begin
                if (sq_en !== 1'b1) bad_old++;
            end else begin
                if (sq_en !== w[31-s]) bad_new++;
            end
            wave_load = 1'b0;
        end
        chk("R6 old pattern kept until wrap", bad_old, 0);
        chk("R4 bits applied from bit 15 down", bad_new, 0);
        count_win(32, nd, ns, nh);
        chk("R5 ones ratio", ns, 14);
        wave_in = 16'h0000; wave_load = 1'b1;
        @(negedge clk);
        wave_load = 1'b0;
        count_win(64, nd, ns, nh);
        chk("R7 zero pattern ignored", ns, 28);
    endtask

    task automatic t_bypass();
        int nd, ns, nh;
        do_reset();
        wave_in = 16'h8001; wave_load = 1'b1;
        @(negedge clk);
        wave_load = 1'b0;
        count_win(32, nd, ns, nh);
        sq_bypass = 1'b1;
        count_win(32, nd, ns, nh);
        chk("R9 squasher bypass passes all", ns, 32);
        sq_bypass = 1'b0;
        count_win(32, nd, ns, nh);
        chk("R5 sparse pattern", ns, 4);
        strobe(2'b11);
        div_bypass = 1'b1;
        count_win(64, nd, ns, nh);
        chk("R8 divider bypass", nd, 64);
        div_bypass = 1'b0;
        count_win(64, nd, ns, nh);
        chk("R2 divide by 8 after bypass", nd, 8);
    endtask

    task automatic t_toggle();
        int bad_h, bad_o;
        do_reset();
        bad_h = 0; bad_o = 0;
        for (int s = 1; s <= 8; s++) begin
            @(negedge clk);
            if (int'(half_clk) != (s % 2)) bad_h++;
            if (int'(half_en) != (s % 2)) bad_o++;
        end
        chk("R10 half_clk toggles", bad_h, 0);
        chk("R10 half_en on falling half", bad_o, 0);
    endtask

    initial begin
        t_reset_state();
        t_div_ratios();
        t_strobe_rule();
        t_pattern();
        t_bypass();
        t_toggle();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule